// File: doc/BRIEF.md
# Mission Sampler with Temperature Histogram

This block runs a temperature logging mission. Register writes set a sample interval in minutes, a start delay in minutes and two control bits. A one-minute tick paces the schedule. When a sample falls due, the block pulses a conversion request to an external sensor. It then waits for the 8-bit reading, which has a resolution of 1/8 °C per LSB.

Each reading goes into one of 64 histogram bins, each 0.5 °C wide. Every bin counter saturates at its maximum value. A mission sample counter and a lifetime sample counter also count each reading. A clear command returns the mission state and the histogram to zero, and a mission may only start after such a clear. A histogram read port lets the surrounding logic fetch any bin.

Write select encoding on `wr_sel`:

| `wr_sel` | Target | Data bits used |
|----------|--------|----------------|
| 0 | sample interval | `wr_data[7:0]` |
| 1 | start delay | `wr_data[15:0]` |
| 2 | control | bit0 = mission inhibit (1 blocks starts), bit1 = clear enable |
| 3 | status | bit0 = mission active; writing 0 stops the mission |

Top module: `mission_sampler`

## Requirements
- R1: After reset, the outputs are as follows. `mission_active`, `mem_cleared`, `sample_busy` and `conv_req` are 0. Both sample counters are 0 and every histogram bin reads 0. Mission inhibit resets to 1 and clear enable resets to 0.
- R2: A `clear_req` pulse acts only when clear enable is 1 and no mission is active. It zeroes the histogram, the mission sample counter, the sample interval and the start delay, and it sets `mem_cleared` to 1. Otherwise it changes none of these. Every `clear_req` pulse returns clear enable to 0.
- R3: A write of a nonzero interval (`wr_sel`=0) starts a mission only when three conditions all hold: no mission is active, `mem_cleared` is 1 and mission inhibit is 0. Starting sets `mission_active` to 1 and `mem_cleared` to 0. A zero interval, or any write that fails one of these conditions, starts nothing.
- R4: With a start delay of D, no sample is taken on the first D minute ticks of a mission. `conv_req` is high for one cycle in the cycle after tick D+1. A delay of 0 samples on the first tick.
- R5: After a sample, the next sample is taken R ticks later, where R is the sample interval.
- R6: Each reading increments histogram bin `reading[7:2]`, and no other bin changes.
- R7: A histogram bin counter that is at its all-ones value stays there when another reading lands in it.
- R8: Both the mission sample counter and the lifetime sample counter (24 bits each) increment once per reading. A clear zeroes only the mission counter.
- R9: `sample_busy` is high from the cycle in which `conv_req` is high until the cycle after the `conv_done` that delivers the reading.
- R10: While a mission is active, writes to the interval and the delay registers are ignored. A status write with bit0 = 0 ends the mission at once, even during the start delay, and no further `conv_req` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see table) |
| wr_data | input | 16 | Register write data |
| clear_req | input | 1 | Clear command pulse |
| minute_tick | input | 1 | One-cycle pulse once per minute |
| conv_req | output | 1 | Conversion request pulse |
| conv_done | input | 1 | Reading valid strobe |
| conv_data | input | 8 | Temperature reading, 1/8 °C per LSB |
| rd_bin | input | 6 | Histogram bin to read |
| rd_count | output | BIN_W | Count of the selected bin |
| mission_active | output | 1 | Mission in progress |
| sample_busy | output | 1 | Conversion outstanding |
| mem_cleared | output | 1 | Memory cleared since the last mission |
| mission_samples | output | 24 | Readings this mission |
| device_samples | output | 24 | Readings over the lifetime |

## Verification
The bench counts ticks against the delay and the interval to catch off-by-one scheduling. An off-by-one design would request on tick D instead of D+1, or space samples R±1 ticks apart. The bench fills one bin past its limit with a narrowed counter; a wrapping counter would read 0 there. It also checks neighbouring bins, which would catch a wrong bin index. The bench tries to start a mission from every blocked state and to clear during a mission. It also stops a mission during its delay; a design that missed the stop would still issue a request on a later tick. A re-armed start after a clear must sample on the first tick, since the clear zeroes the delay.

// File: rtl/mission_sampler.sv
module mission_sampler #(
  parameter int BIN_W     = 16,
  parameter int RATE_W    = 8,
  parameter int DLY_W     = 16,
  parameter int CNT_W     = 24,
  parameter int RD_W      = 8,
  parameter int BIN_SHIFT = 2,
  localparam int IDX_W    = RD_W - BIN_SHIFT,
  localparam int NBINS    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DLY_W-1:0] wr_data,
  input  logic             clear_req,
  input  logic             minute_tick,
  output logic             conv_req,
  input  logic             conv_done,
  input  logic [RD_W-1:0]  conv_data,
  input  logic [IDX_W-1:0] rd_bin,
  output logic [BIN_W-1:0] rd_count,
  output logic             mission_active,
  output logic             sample_busy,
  output logic             mem_cleared,
  output logic [CNT_W-1:0] mission_samples,
  output logic [CNT_W-1:0] device_samples
);
  logic [RATE_W-1:0] rate, ivl_cnt;
  logic [DLY_W-1:0]  delay;
  logic              inhibit, clr_en, waiting;
  logic [BIN_W-1:0]  hist [NBINS];

  wire wr_rate  = wr_en && wr_sel == 2'd0;
  wire wr_dly   = wr_en && wr_sel == 2'd1;
  wire wr_ctl   = wr_en && wr_sel == 2'd2;
  wire stop     = wr_en && wr_sel == 2'd3 && !wr_data[0];
  wire do_clear = clear_req && clr_en && !mission_active;
  wire start    = wr_rate && (|wr_data[RATE_W-1:0]) && !mission_active
                  && mem_cleared && !inhibit && !do_clear;
  wire due      = mission_active && minute_tick
                  && (waiting ? delay == '0 : ivl_cnt == '0);
  wire fire     = due && !sample_busy && !stop;
  wire landed   = sample_busy && conv_done;
  wire [IDX_W-1:0] bin = conv_data[RD_W-1:BIN_SHIFT];
  wire bin_full = &hist[bin];

  assign rd_count = hist[rd_bin];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate            <= '0;
      ivl_cnt         <= '0;
      delay           <= '0;
      inhibit         <= 1'b1;
      clr_en          <= 1'b0;
      waiting         <= 1'b0;
      conv_req        <= 1'b0;
      mission_active  <= 1'b0;
      sample_busy     <= 1'b0;
      mem_cleared     <= 1'b0;
      mission_samples <= '0;
      device_samples  <= '0;
      for (int i = 0; i < NBINS; i++) hist[i] <= '0;
    end else begin
      conv_req <= fire;
      if (fire) sample_busy <= 1'b1;
      else if (landed) sample_busy <= 1'b0;

      if (landed) begin
        if (!bin_full) hist[bin] <= hist[bin] + 1'b1;
        mission_samples <= mission_samples + 1'b1;
        device_samples  <= device_samples + 1'b1;
      end

      if (wr_ctl) begin
        inhibit <= wr_data[0];
        clr_en  <= wr_data[1];
      end
      if (clear_req) clr_en <= 1'b0;

      if (wr_rate && !mission_active) rate  <= wr_data[RATE_W-1:0];
      if (wr_dly  && !mission_active) delay <= wr_data;

      if (start) begin
        mission_active <= 1'b1;
        mem_cleared    <= 1'b0;
        waiting        <= 1'b1;
      end

      if (mission_active && minute_tick) begin
        if (waiting) begin
          if (delay == '0) begin
            waiting <= 1'b0;
            ivl_cnt <= rate - 1'b1;
          end else
            delay <= delay - 1'b1;
        end else if (ivl_cnt == '0)
          ivl_cnt <= rate - 1'b1;
        else
          ivl_cnt <= ivl_cnt - 1'b1;
      end

      if (stop) mission_active <= 1'b0;

      if (do_clear) begin
        for (int i = 0; i < NBINS; i++) hist[i] <= '0;
        mission_samples <= '0;
        rate            <= '0;
        delay           <= '0;
        mem_cleared     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mission_sampler_chk.sv
module mission_sampler_chk #(
  parameter int RATE_W = 8,
  parameter int DLY_W  = 16,
  parameter int CNT_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [DLY_W-1:0] wr_data,
  input logic             clear_req,
  input logic             conv_req,
  input logic             conv_done,
  input logic             mission_active,
  input logic             sample_busy,
  input logic             mem_cleared,
  input logic [CNT_W-1:0] mission_samples,
  input logic [CNT_W-1:0] device_samples
);
  a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> sample_busy);

  a_r9_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_busy) |-> $past(conv_done));

  a_r8_dev_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (device_samples == $past(device_samples)
              || device_samples == $past(device_samples) + 1'b1));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mission_active && mem_cleared));

  a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mission_active) |-> $past(wr_en && wr_sel == 2'd0
                                    && wr_data[RATE_W-1:0] != '0 && mem_cleared));

  a_r10_req_in_mission: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> $past(mission_active));

  a_r2_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cleared) |-> ($past(clear_req) && mission_samples == '0));
endmodule

bind mission_sampler mission_sampler_chk #(
  .RATE_W(RATE_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/mission_sampler_tb_top.sv
module mission_sampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, clear_req = 0, minute_tick = 0, conv_done = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] conv_data = 0;
  logic [5:0] rd_bin = 0;
  logic conv_req, mission_active, sample_busy, mem_cleared;
  logic [BW-1:0] rd_count;
  logic [23:0] mission_samples, device_samples;

  int checks = 0, fails = 0, req_seen = 0;
  logic [7:0] rdq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mission_sampler #(.BIN_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clear_req(clear_req), .minute_tick(minute_tick), .conv_req(conv_req),
    .conv_done(conv_done), .conv_data(conv_data), .rd_bin(rd_bin),
    .rd_count(rd_count), .mission_active(mission_active),
    .sample_busy(sample_busy), .mem_cleared(mem_cleared),
    .mission_samples(mission_samples), .device_samples(device_samples));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: answers each request with the next expected reading
  always @(negedge clk) begin
    conv_done = 0;
    if (rst_n && conv_req) begin
      req_seen++;
      chk("R9 busy with request", sample_busy, 1);
      if (rdq.size() == 0) chk("R10 unexpected request", 1, 0);
      else begin
        conv_data = rdq.pop_front();
        conv_done = 1;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clr();
    @(negedge clk); clear_req = 1;
    @(negedge clk); clear_req = 0;
  endtask

  task automatic tick();
    @(negedge clk); minute_tick = 1;
    @(negedge clk); minute_tick = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 busy released", sample_busy, 0);
  endtask

  task automatic bin_is(input int b, input int exp, input string tag);
    rd_bin = 6'(b); #1;
    chk(tag, rd_count, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mission_active", mission_active, 0);
    chk("R1 mem_cleared", mem_cleared, 0);
    chk("R1 sample_busy", sample_busy, 0);
    chk("R1 conv_req", conv_req, 0);
    chk("R1 device_samples", device_samples, 0);
    bin_is(0, 0, "R1 bin0");

    wr(2'd0, 16'd3);
    chk("R3 no start before clear", mission_active, 0);
    clr();
    chk("R2 clear without enable", mem_cleared, 0);
    wr(2'd2, 16'h2);
    clr();
    chk("R2 clear sets mem_cleared", mem_cleared, 1);

    wr(2'd2, 16'h1);
    wr(2'd0, 16'd3);
    chk("R3 inhibit blocks start", mission_active, 0);
    wr(2'd2, 16'h0);
    wr(2'd0, 16'd0);
    chk("R3 zero rate no start", mission_active, 0);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd3);
    chk("R3 start", mission_active, 1);
    chk("R3 mem_cleared drops", mem_cleared, 0);

    rdq.push_back(8'h00); rdq.push_back(8'h03);
    rdq.push_back(8'h07); rdq.push_back(8'hFF);
    r = req_seen;
    tick(); tick();
    chk("R4 no sample during delay", req_seen, r);
    tick();
    chk("R4 first sample after delay", req_seen, r + 1);
    tick(); tick();
    chk("R5 no sample mid interval", req_seen, r + 1);
    tick();
    chk("R5 second sample", req_seen, r + 2);
    tick(); tick(); tick();
    tick(); tick(); tick();
    chk("R5 fourth sample", req_seen, r + 4);
    bin_is(0, 2, "R6 bin0");
    bin_is(1, 1, "R6 bin1");
    bin_is(63, 1, "R6 bin63");
    bin_is(2, 0, "R6 bin2 untouched");
    chk("R8 mission_samples", mission_samples, 4);
    chk("R8 device_samples", device_samples, 4);

    wr(2'd0, 16'd1);
    rdq.push_back(8'h04);
    r = req_seen;
    tick(); tick();
    chk("R10 rate write ignored in mission", req_seen, r);
    tick();
    chk("R10 old rate kept", req_seen, r + 1);
    bin_is(1, 2, "R6 bin1 again");

    for (int k = 0; k < 16; k++) begin
      rdq.push_back(8'h80);
      tick(); tick(); tick();
      if (k == 14) bin_is(32, 15, "R7 bin32 at max");
    end
    bin_is(32, 15, "R7 saturated bin32");
    bin_is(33, 0, "R6 bin33 untouched");
    chk("R8 mission_samples 21", mission_samples, 21);

    wr(2'd3, 16'h0);
    chk("R10 stop", mission_active, 0);
    r = req_seen;
    tick(); tick(); tick();
    chk("R10 no request after stop", req_seen, r);

    wr(2'd2, 16'h2);
    clr();
    chk("R2 clear after stop", mem_cleared, 1);
    bin_is(32, 0, "R2 histogram zeroed");
    chk("R8 mission cleared", mission_samples, 0);
    chk("R8 lifetime kept", device_samples, 21);

    wr(2'd0, 16'd1);
    rdq.push_back(8'h10); rdq.push_back(8'h11);
    r = req_seen;
    tick();
    chk("R4 delay zeroed by clear", req_seen, r + 1);
    tick();
    chk("R5 rate one", req_seen, r + 2);
    bin_is(4, 2, "R6 bin4");
    chk("R8 device 23", device_samples, 23);

    wr(2'd2, 16'h2);
    clr();
    chk("R2 clear blocked in mission", mem_cleared, 0);
    chk("R2 mission survives clear", mission_active, 1);
    bin_is(4, 2, "R2 bins kept");
    wr(2'd3, 16'h0);
    clr();
    chk("R2 enable self-cleared", mem_cleared, 0);

    wr(2'd2, 16'h2);
    clr();
    wr(2'd1, 16'd5);
    wr(2'd0, 16'd2);
    chk("R3 restart", mission_active, 1);
    r = req_seen;
    tick(); tick();
    wr(2'd3, 16'h0);
    chk("R10 stop in delay", mission_active, 0);
    for (int k = 0; k < 8; k++) tick();
    chk("R10 no request after delay stop", req_seen, r);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule